// File: doc/BRIEF.md
# Serial Readback Stream Controller

This block turns the contents of a configuration memory into one serial bit stream when it is asked to. A rising edge on the trigger input, sampled by the readback clock, starts a transfer. The busy output then stays high while the stream is shifted out one bit per clock edge. The stream opens with a short run of high dummy bits. Each frame follows, made of a low start bit, the frame's data bits and a group of check bits that are always high. The tail is a closing low start bit and an 11-bit CRC signature that covers everything sent after the dummy run.

The memory array sits outside the block. The block presents a frame index and a bit index, and the array returns the addressed bit combinationally on `mem_bit`. A capture mode replaces a fixed window of data bits in every frame with the inverted values of live signals, latched at the starting edge. An abort mode stops a transfer when the trigger falls. After an abort, the control logic spends one clock per frame re-initialising before it accepts a new trigger.

Top module: `rbk_stream_ctrl`

## Requirements
- R1: When the block is idle, a trigger rise (trigger low at one clock edge and high at the next) drives `busy` high at the second of those edges. After that, every clock edge moves exactly one new stream bit onto `dout`.
- R2: The first five stream bits are 1. Every frame then begins with one 0 start bit, and its FRAME_BITS data bits follow in index order, from bit 0 upward.
- R3: Data bits 0 and 1 of frame 0 are always sent as 1.
- R4: Every frame closes with four check bits, all sent as 1.
- R5: The last seven data bits of the last frame are always sent as 1.
- R6: After the last frame the block sends one 0 bit and then the 11 CRC bits, most significant first. `busy` falls on the edge that follows the last CRC bit. `dout` is 1 whenever no stream bit is being sent.
- R7: The CRC register starts at zero. It takes in every stream bit from the first frame's start bit through the closing 0 bit. For each bit b: fb = crc[10] XOR b, then crc = (crc << 1) XOR (fb ? CRC_POLY : 0), truncated to 11 bits. The default CRC_POLY is 11'h307.
- R8: If `cap_en` is high at the starting edge, `live_in` is latched at that edge. In that case, data bit CAP_POS+k of frame f (k below CAP_PER) carries the inverse of `live_in[f*CAP_PER+k]`. If `cap_en` is low, those bits carry the memory contents. The forced-high rules of R3 and R5 take priority over capture.
- R9: During the cycle before a data bit's edge, `frame_sel` and `bit_sel` present that bit's frame and data index. The value on `mem_bit` is then sent, unless R3, R5 or R8 override it.
- R10: If `abort_en` is high and a trigger fall (high at one edge, low at the next) is sampled while `busy` is high, `busy` drops at that edge and `dout` returns to 1. If `abort_en` is low, a fall has no effect.
- R11: After an abort, the block ignores trigger rises for the next NUM_FRAMES clock edges. After that it accepts a new rise.
- R12: A trigger rise sampled while `busy` is high is ignored. This includes a rise sampled at the edge where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readback clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Trigger level; a rise starts a transfer, a fall aborts one when enabled |
| cap_en | input | 1 | Capture mode select, sampled at the starting edge |
| abort_en | input | 1 | Enables abort on a trigger fall |
| live_in | input | NUM_FRAMES*CAP_PER | Live signals sampled for capture |
| mem_bit | input | 1 | Memory bit addressed by frame_sel and bit_sel |
| frame_sel | output | max(1,clog2(NUM_FRAMES)) | Frame index of the data bit being fetched |
| bit_sel | output | clog2 of the largest phase length | Data bit index within the frame |
| dout | output | 1 | Serial stream output |
| busy | output | 1 | High while a transfer is in progress |

## Verification
Two of the block's functions can fall on the same clock edge: the end of a transfer and the detection of a new trigger rise. The bench lowers the trigger two bits before the end of the stream and raises it again so that the rise is sampled at the exact edge where `busy` falls. It then checks that `busy` stays low for several cycles, which means the rise was dropped. A second pairing puts an abort and a re-trigger close together: a rise that lands inside the re-initialisation window must be lost. A rise made after that window must produce a complete stream, whose bits the scoreboard compares one by one.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

  localparam int DUMMY_N   = 5;
  localparam int CHECK_N   = 4;
  localparam int LEAD_HIGH = 2;
  localparam int TAIL_HIGH = 7;
  localparam int CRC_W     = 11;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DUMMY,
    PH_START,
    PH_DATA,
    PH_CHECK,
    PH_FSTART,
    PH_CRC,
    PH_DONE,
    PH_REINIT
  } phase_t;

  // one serial step of the signature register
  function automatic logic [CRC_W-1:0] crc_step(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  function automatic int width_for(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int stream_len(input int nf, input int fb);
    return DUMMY_N + nf * (1 + fb + CHECK_N) + 1 + CRC_W;
  endfunction

endpackage

// File: rtl/rbk_trig_edge.sv
module rbk_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise,
  output logic fall
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign rise = trig & ~trig_q;
  assign fall = ~trig & trig_q;
endmodule

// File: rtl/rbk_seq.sv
module rbk_seq
  import rbk_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = 4,
  parameter int FRM_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             fall,
  input  logic             abort_en,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic [FRM_W-1:0] frm,
  output logic             start_evt,
  output logic             abort_evt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_N - 1);
  localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CHECK_LAST = CNT_W'(CHECK_N - 1);
  localparam logic [CNT_W-1:0] CRC_LAST   = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(NUM_FRAMES - 1);
  localparam logic [FRM_W-1:0] FRM_LAST   = FRM_W'(NUM_FRAMES - 1);

  assign busy      = (phase != PH_IDLE) && (phase != PH_REINIT);
  assign start_evt = rise && (phase == PH_IDLE);
  assign abort_evt = abort_en && fall && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      frm   <= '0;
    end else if (abort_evt) begin
      phase <= PH_REINIT;
      cnt   <= '0;
      frm   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start_evt) begin
            phase <= PH_DUMMY;
            cnt   <= '0;
            frm   <= '0;
          end
        end
        PH_DUMMY: begin
          if (cnt == DUMMY_LAST) begin
            phase <= PH_START;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_START: begin
          phase <= PH_DATA;
          cnt   <= '0;
        end
        PH_DATA: begin
          if (cnt == DATA_LAST) begin
            phase <= PH_CHECK;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_CHECK: begin
          if (cnt == CHECK_LAST) begin
            cnt <= '0;
            if (frm == FRM_LAST) phase <= PH_FSTART;
            else begin
              phase <= PH_START;
              frm   <= frm + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        PH_FSTART: begin
          phase <= PH_CRC;
          cnt   <= '0;
        end
        PH_CRC: begin
          if (cnt == CRC_LAST) begin
            phase <= PH_DONE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_DONE: begin
          phase <= PH_IDLE;
        end
        PH_REINIT: begin
          if (cnt == INIT_LAST) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbk_bit_sel.sv
module rbk_bit_sel
  import rbk_pkg::*;
#(
  parameter int NUM_FRAMES = 3,
  parameter int FRAME_BITS = 16,
  parameter int CAP_POS    = 4,
  parameter int CAP_PER    = 3,
  parameter int CNT_W      = 4,
  parameter int FRM_W      = 2
) (
  input  phase_t                          phase,
  input  logic [CNT_W-1:0]                cnt,
  input  logic [FRM_W-1:0]                frm,
  input  logic                            mem_bit,
  input  logic                            cap_on,
  input  logic [NUM_FRAMES*CAP_PER-1:0]   cap_bits,
  input  logic [CRC_W-1:0]                crc,
  output logic                            tx_bit,
  output logic                            tx_emit,
  output logic                            crc_take
);
  localparam int CAP_TOT = NUM_FRAMES * CAP_PER;

  logic [CRC_W-1:0] crc_sh;
  logic             data_bit;

  assign crc_sh = crc << cnt;

  always_comb begin
    int fi;
    int bi;
    int ci;
    fi = int'(frm);
    bi = int'(cnt);
    ci = fi * CAP_PER + (bi - CAP_POS);
    data_bit = mem_bit;
    if (fi == 0 && bi < LEAD_HIGH) begin
      data_bit = 1'b1;
    end else if (fi == NUM_FRAMES - 1 && bi >= FRAME_BITS - TAIL_HIGH) begin
      data_bit = 1'b1;
    end else if (cap_on && bi >= CAP_POS && bi < CAP_POS + CAP_PER) begin
      for (int k = 0; k < CAP_TOT; k++) begin
        if (k == ci) data_bit = ~cap_bits[k];
      end
    end
  end

  always_comb begin
    tx_bit   = 1'b1;
    tx_emit  = 1'b1;
    crc_take = 1'b0;
    unique case (phase)
      PH_DUMMY:  tx_bit = 1'b1;
      PH_START:  begin tx_bit = 1'b0;     crc_take = 1'b1; end
      PH_DATA:   begin tx_bit = data_bit; crc_take = 1'b1; end
      PH_CHECK:  begin tx_bit = 1'b1;     crc_take = 1'b1; end
      PH_FSTART: begin tx_bit = 1'b0;     crc_take = 1'b1; end
      PH_CRC:    tx_bit = crc_sh[CRC_W-1];
      default:   tx_emit = 1'b0;
    endcase
  end
endmodule

// File: rtl/rbk_crc.sv
module rbk_crc
  import rbk_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 11'h307
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= '0;
    else if (clear) crc <= '0;
    else if (take)  crc <= crc_step(crc, din, CRC_POLY);
  end
endmodule

// File: rtl/rbk_stream_ctrl.sv
module rbk_stream_ctrl
  import rbk_pkg::*;
#(
  parameter int                NUM_FRAMES = 3,
  parameter int                FRAME_BITS = 16,
  parameter int                CAP_POS    = 4,
  parameter int                CAP_PER    = 3,
  parameter logic [CRC_W-1:0]  CRC_POLY   = 11'h307,
  localparam int               CAP_TOT    = NUM_FRAMES * CAP_PER,
  localparam int               FRM_W      = width_for(NUM_FRAMES),
  localparam int               CNT_W      = width_for(max4(FRAME_BITS, CRC_W, DUMMY_N, NUM_FRAMES))
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic               cap_en,
  input  logic               abort_en,
  input  logic [CAP_TOT-1:0] live_in,
  input  logic               mem_bit,
  output logic [FRM_W-1:0]   frame_sel,
  output logic [CNT_W-1:0]   bit_sel,
  output logic               dout,
  output logic               busy
);
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [FRM_W-1:0]   frm;
  logic               trig_rise;
  logic               trig_fall;
  logic               start_evt;
  logic               abort_evt;
  logic               end_evt;
  logic               check_evt;
  logic               reinit_act;
  logic               tx_bit;
  logic               tx_emit;
  logic               crc_take;
  logic [CRC_W-1:0]   crc;
  logic               cap_on_q;
  logic [CAP_TOT-1:0] cap_q;
  logic               dout_q;

  rbk_trig_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig),
    .rise  (trig_rise),
    .fall  (trig_fall)
  );

  rbk_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .FRAME_BITS (FRAME_BITS),
    .CNT_W      (CNT_W),
    .FRM_W      (FRM_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise      (trig_rise),
    .fall      (trig_fall),
    .abort_en  (abort_en),
    .phase     (phase),
    .cnt       (cnt),
    .frm       (frm),
    .start_evt (start_evt),
    .abort_evt (abort_evt),
    .busy      (busy)
  );

  rbk_bit_sel #(
    .NUM_FRAMES (NUM_FRAMES),
    .FRAME_BITS (FRAME_BITS),
    .CAP_POS    (CAP_POS),
    .CAP_PER    (CAP_PER),
    .CNT_W      (CNT_W),
    .FRM_W      (FRM_W)
  ) u_bits (
    .phase    (phase),
    .cnt      (cnt),
    .frm      (frm),
    .mem_bit  (mem_bit),
    .cap_on   (cap_on_q),
    .cap_bits (cap_q),
    .crc      (crc),
    .tx_bit   (tx_bit),
    .tx_emit  (tx_emit),
    .crc_take (crc_take)
  );

  rbk_crc #(.CRC_POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_evt),
    .take  (crc_take && !abort_evt),
    .din   (tx_bit),
    .crc   (crc)
  );

  assign end_evt    = (phase == PH_DONE);
  assign check_evt  = (phase == PH_CHECK);
  assign reinit_act = (phase == PH_REINIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_on_q <= 1'b0;
      cap_q    <= '0;
    end else if (start_evt) begin
      cap_on_q <= cap_en;
      if (cap_en) cap_q <= live_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dout_q <= 1'b1;
    else if (abort_evt)            dout_q <= 1'b1;
    else if (tx_emit)              dout_q <= tx_bit;
    else                           dout_q <= 1'b1;
  end

  assign dout      = dout_q;
  assign frame_sel = frm;
  assign bit_sel   = cnt;
endmodule

// File: rtl/rbk_stream_chk.sv
module rbk_stream_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic dout,
  input logic start_evt,
  input logic abort_evt,
  input logic end_evt,
  input logic check_evt,
  input logic reinit_act
);
  // R1: a start raises busy on the same edge
  a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  // R1: busy never rises without a start
  a_r1_rise_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_evt));

  // R2: the first stream bit is high
  a_r2_first_dummy_high: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> ##1 dout);

  // R4: check positions always leave a high bit
  a_r4_check_high: assert property (@(posedge clk) disable iff (!rst_n)
    check_evt |=> dout);

  // R6: completion drops busy and idles the line high
  a_r6_end_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (!busy && dout));

  // R10: an abort drops busy and idles the line high
  a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && dout));

  // R11: no transfer may start out of re-initialisation
  a_r11_reinit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_act |=> !busy);

  // R12: busy only ends through completion or abort
  a_r12_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_evt && !abort_evt) |=> busy);
endmodule

bind rbk_stream_ctrl rbk_stream_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .dout       (dout),
  .start_evt  (start_evt),
  .abort_evt  (abort_evt),
  .end_evt    (end_evt),
  .check_evt  (check_evt),
  .reinit_act (reinit_act)
);

// File: tb/test_rbk_stream_ctrl.sv
module test_rbk_stream_ctrl;
  localparam int NF   = 3;
  localparam int FB   = 16;
  localparam int CPOS = 4;
  localparam int CPER = 3;
  localparam int POLY = 'h307;
  localparam int CT   = NF * CPER;
  localparam int SLEN = 5 + NF * (1 + FB + 4) + 1 + 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic          cap_en = 1'b0;
  logic          abort_en = 1'b0;
  logic [CT-1:0] live_in = '0;
  logic          mem_bit;
  logic [1:0]    frame_sel;
  logic [3:0]    bit_sel;
  logic          dout;
  logic          busy;

  int n_checks = 0;
  int n_fail   = 0;
  int seed     = 0;
  int cycles   = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  rbk_stream_ctrl i_rbk_stream_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .cap_en    (cap_en),
    .abort_en  (abort_en),
    .live_in   (live_in),
    .mem_bit   (mem_bit),
    .frame_sel (frame_sel),
    .bit_sel   (bit_sel),
    .dout      (dout),
    .busy      (busy)
  );

  function automatic bit mem_model(int f, int b, int s);
    return ((f * 5 + b * 3 + s) % 7) < 3;
  endfunction

  always_comb mem_bit = mem_model(int'(frame_sel), int'(bit_sel), seed);

  task automatic check(string req, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: expected stream pushed into the scoreboard
  task automatic push_stream(bit cap, logic [CT-1:0] live);
    int sig;
    bit b;
    sig = 0;
    for (int i = 0; i < 5; i++) begin exp_q.push_back(1'b1); tag_q.push_back("R2"); end
    for (int f = 0; f < NF; f++) begin
      exp_q.push_back(1'b0); tag_q.push_back("R2");
      sig = ((sig << 1) & 'h7ff) ^ ((((sig >> 10) & 1) != 0) ? POLY : 0);
      for (int d = 0; d < FB; d++) begin
        string t;
        if (f == 0 && d < 2) begin b = 1'b1; t = "R3"; end
        else if (f == NF - 1 && d >= FB - 7) begin b = 1'b1; t = "R5"; end
        else if (cap && d >= CPOS && d < CPOS + CPER) begin b = ~live[f * CPER + d - CPOS]; t = "R8"; end
        else begin b = mem_model(f, d, seed); t = "R9"; end
        exp_q.push_back(b); tag_q.push_back(t);
        sig = ((sig << 1) & 'h7ff) ^ (((((sig >> 10) & 1) ^ int'(b)) != 0) ? POLY : 0);
      end
      for (int c = 0; c < 4; c++) begin
        exp_q.push_back(1'b1); tag_q.push_back("R4");
        sig = ((sig << 1) & 'h7ff) ^ ((((sig >> 10) & 1) != 1) ? POLY : 0);
      end
    end
    exp_q.push_back(1'b0); tag_q.push_back("R6");
    sig = ((sig << 1) & 'h7ff) ^ ((((sig >> 10) & 1) != 0) ? POLY : 0);
    for (int k = 10; k >= 0; k--) begin
      exp_q.push_back(((sig >> k) & 1) != 0); tag_q.push_back("R7");
    end
  endtask

  // monitor side: pops and compares one bit per clock
  task automatic run_stream(int s, bit cap, logic [CT-1:0] live, int toggle_at, bit hit_end);
    seed = s;
    exp_q.delete(); tag_q.delete();
    push_stream(cap, live);
    @(negedge clk);
    cap_en = cap; live_in = live; trig = 1'b1;
    @(negedge clk);
    check("R1 busy after rise", busy, 1'b1);
    live_in = ~live;
    for (int i = 0; i < SLEN; i++) begin
      bit e;
      string t;
      @(negedge clk);
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(t, dout, e);
      check("R12 busy held", busy, 1'b1);
      if (i == toggle_at) trig = 1'b0;
      if (i == toggle_at + 1) trig = 1'b1;
      if (hit_end && i == SLEN - 2) trig = 1'b0;
      if (hit_end && i == SLEN - 1) trig = 1'b1;
    end
    @(negedge clk);
    check("R6 busy falls", busy, 1'b0);
    check("R6 idle high", dout, 1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R12 late rise ignored", busy, 1'b0);
    end
    trig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R6 reset busy", busy, 1'b0);
    check("R6 reset dout", dout, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_stream(0, 1'b0, 9'b101100110, -10, 1'b0);
    run_stream(4, 1'b1, 9'b101100110, -10, 1'b0);
    run_stream(2, 1'b1, 9'b010011001, 30, 1'b0);
    run_stream(6, 1'b0, 9'b111111111, -10, 1'b1);

    // R10/R11: abort then re-trigger inside the re-init window
    abort_en = 1'b1;
    seed = 1;
    @(negedge clk); trig = 1'b1;
    repeat (20) @(negedge clk);
    check("R10 busy before abort", busy, 1'b1);
    trig = 1'b0;
    @(negedge clk);
    check("R10 abort busy", busy, 1'b0);
    check("R10 abort dout", dout, 1'b1);
    trig = 1'b1;
    for (int i = 0; i < NF + 2; i++) begin
      @(negedge clk);
      check("R11 rise in reinit ignored", busy, 1'b0);
    end
    trig = 1'b0;
    @(negedge clk);
    run_stream(3, 1'b0, '0, -10, 1'b0);
    abort_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule